// File: doc/BRIEF.md
# Crystal Oscillator Control and Clock Divider

This block is the digital side of an external crystal oscillator. A mode controller drives an enable request. The block holds the oscillator clock path at 0 while that request is low, and passes the raw oscillator input through while it is high. Each time the enable turns on, a startup counter begins counting. When the count reaches a programmed settling threshold, the block declares the clock stable, raises a ready status and sets an interrupt-pending flag. An interrupt line follows that flag through a mask.

A small write port loads four things: the settling threshold field, the interrupt mask, a sticky bypass bit and a 5-bit divide selector. The same write can also clear the pending flag. In bypass the raw input goes straight to the output clock, and ready is forced high whatever the enable is doing. A divider produces a one-cycle clock-enable pulse once every 1 to 32 cycles of the oscillator clock.

All of the logic runs on `clk`, which is the oscillator-domain clock. `ext_clk` is the raw input that the output clock gate passes or blocks.

Top module: `xosc_ctl`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `osc_ready`, `osc_irq`, `pend_flag`, `byp_flag`, `clk_out` and `div_ce` are all 0. The enable request is also 0 during this time.
- R2: Let T = `wr_eoc` × 512, using the field value last written. `osc_ready` rises at the (T+1)-th rising edge after the edge that first samples `osc_en` high. A field value of 0 gives ready at the first edge.
- R3: When the startup count completes, `pend_flag` is set to 1 at that same edge.
- R4: `osc_irq` is 1 exactly when `pend_flag` is 1 and the stored mask bit is 1. A mask value of 0 blocks the interrupt but leaves the flag unchanged.
- R5: A write with `wr_pend_clr`=1 clears `pend_flag` at that edge. A write with `wr_pend_clr`=0 leaves it unchanged. If a completion and a clearing write occur on the same edge, the flag ends up set.
- R6: A write with `wr_byp`=1 sets `byp_flag`. A write with `wr_byp`=0 has no effect on it. Only reset clears it.
- R7: While `byp_flag` is 1, `osc_ready` is 1 and `clk_out` equals `ext_clk`, for either value of `osc_en`.
- R8: With `osc_en`=0 and `byp_flag`=0, `clk_out` is 0. With `osc_en`=1, `clk_out` equals `ext_clk`.
- R9: After `osc_en` goes low without bypass, `osc_ready` is 0 from the next edge on. A later rise of `osc_en` restarts the full count from zero.
- R10: The divide field holds factor−1. While the clock path is active, `div_ce` is high for one cycle out of every (field+1) cycles, so a field of 0 divides by 1 and a field of 31 divides by 32. While the path is inactive, `div_ce` stays at 0.
- R11: A new divide value takes effect only at the next terminal count. The period that is running when the value is written completes at its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| osc_en | input | 1 | Power-on request from the mode controller |
| ext_clk | input | 1 | Raw oscillator / external clock input |
| wr_en | input | 1 | Register write strobe |
| wr_eoc | input | 8 | Settling threshold field (threshold = value × 512) |
| wr_mask | input | 1 | Interrupt mask, 1 enables the interrupt |
| wr_div | input | 5 | Divide selector, factor − 1 |
| wr_byp | input | 1 | 1 sets the sticky bypass bit |
| wr_pend_clr | input | 1 | 1 clears the pending flag |
| osc_ready | output | 1 | Oscillator clock available |
| osc_irq | output | 1 | Interrupt request |
| pend_flag | output | 1 | Interrupt-pending flag |
| byp_flag | output | 1 | Bypass bit state |
| clk_out | output | 1 | Gated undivided clock |
| div_ce | output | 1 | Divided clock-enable pulse |

## Verification
The assertions check several rules on every cycle:
- the output clock is quiet whenever the path is powered down and not bypassed;
- bypass forces ready and passes the input, and once set it stays set;
- a completion event always leaves the pending flag set at the next cycle, and a clearing write without a completion leaves it cleared;
- the interrupt never fires without a pending flag;
- readiness drops after a loss of enable.

Only the bench scenarios can show the exact startup latency for each threshold value, the divide period for every selector value, and the rule that a divide change waits for the running period to finish. These depend on cycle counts that the bench measures against arithmetic it does on its own.

// File: rtl/xosc_pkg.sv
package xosc_pkg;

  // Settling threshold: field scaled by a power of two.
  function automatic int unsigned settle_cycles(input int unsigned field, input int unsigned scale_lg);
    return field << scale_lg;
  endfunction

  // Divider terminal test: selector encodes period minus one.
  function automatic logic div_terminal(input int unsigned count, input int unsigned sel);
    return count == sel;
  endfunction

endpackage

// File: rtl/xosc_regs.sv
module xosc_regs #(
  parameter int EOC_W = 8,
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [EOC_W-1:0] wr_eoc,
  input  logic             wr_mask,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_byp,
  input  logic             wr_pend_clr,
  input  logic             done_evt,
  output logic [EOC_W-1:0] eoc_q,
  output logic             mask_q,
  output logic [DIV_W-1:0] div_q,
  output logic             byp_q,
  output logic             pend_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_q  <= '0;
      mask_q <= 1'b0;
      div_q  <= '0;
    end else if (wr_en) begin
      eoc_q  <= wr_eoc;
      mask_q <= wr_mask;
      div_q  <= wr_div;
    end
  end

  // Sticky bypass: set by write, cleared by reset only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                byp_q <= 1'b0;
    else if (wr_en && wr_byp)  byp_q <= 1'b1;
  end

  // Pending flag: completion has priority over a clearing write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      pend_q <= 1'b0;
    else if (done_evt)               pend_q <= 1'b1;
    else if (wr_en && wr_pend_clr)   pend_q <= 1'b0;
  end

endmodule

// File: rtl/xosc_startup.sv
module xosc_startup #(
  parameter int EOC_W    = 8,
  parameter int SCALE_LG = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic [EOC_W-1:0] eoc,
  output logic             stable,
  output logic             start_evt,
  output logic             done_evt
);

  localparam int CNT_W = EOC_W + SCALE_LG;

  logic             en_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;

  assign limit     = CNT_W'(xosc_pkg::settle_cycles(32'(eoc), SCALE_LG));
  assign start_evt = osc_en && !en_q;
  assign done_evt  = osc_en && en_q && !stable && (cnt == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      cnt    <= '0;
      stable <= 1'b0;
    end else begin
      en_q <= osc_en;
      if (!osc_en || start_evt) begin
        cnt    <= '0;
        stable <= 1'b0;
      end else if (done_evt) begin
        stable <= 1'b1;
      end else if (!stable) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/xosc_divider.sv
module xosc_divider #(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_sel,
  output logic             tc_evt
);

  logic [DIV_W-1:0] dcnt;
  logic [DIV_W-1:0] act_sel;

  assign tc_evt = run && xosc_pkg::div_terminal(32'(dcnt), 32'(act_sel));

  // The active selector reloads only at a terminal count or while idle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dcnt    <= '0;
      act_sel <= '0;
    end else if (!run || tc_evt) begin
      dcnt    <= '0;
      act_sel <= div_sel;
    end else begin
      dcnt <= dcnt + 1'b1;
    end
  end

endmodule

// File: rtl/xosc_ctl.sv
module xosc_ctl #(
  parameter int EOC_W    = 8,
  parameter int SCALE_LG = 9,
  parameter int DIV_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_en,
  input  logic             ext_clk,
  input  logic             wr_en,
  input  logic [EOC_W-1:0] wr_eoc,
  input  logic             wr_mask,
  input  logic [DIV_W-1:0] wr_div,
  input  logic             wr_byp,
  input  logic             wr_pend_clr,
  output logic             osc_ready,
  output logic             osc_irq,
  output logic             pend_flag,
  output logic             byp_flag,
  output logic             clk_out,
  output logic             div_ce
);

  logic [EOC_W-1:0] eoc_q;
  logic [DIV_W-1:0] div_q;
  logic             mask_q;
  logic             stable_q;
  logic             start_evt;
  logic             done_evt;
  logic             path_on;

  xosc_regs #(.EOC_W(EOC_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_eoc(wr_eoc),
    .wr_mask(wr_mask), .wr_div(wr_div), .wr_byp(wr_byp),
    .wr_pend_clr(wr_pend_clr), .done_evt(done_evt),
    .eoc_q(eoc_q), .mask_q(mask_q), .div_q(div_q),
    .byp_q(byp_flag), .pend_q(pend_flag)
  );

  xosc_startup #(.EOC_W(EOC_W), .SCALE_LG(SCALE_LG)) u_start (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .eoc(eoc_q),
    .stable(stable_q), .start_evt(start_evt), .done_evt(done_evt)
  );

  assign path_on = osc_en || byp_flag;

  xosc_divider #(.DIV_W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(path_on), .div_sel(div_q),
    .tc_evt(div_ce)
  );

  assign clk_out   = path_on ? ext_clk : 1'b0;
  assign osc_ready = stable_q || byp_flag;
  assign osc_irq   = pend_flag && mask_q;

endmodule

// File: rtl/xosc_ctl_chk.sv
module xosc_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic osc_en,
  input logic ext_clk,
  input logic wr_en,
  input logic wr_pend_clr,
  input logic osc_ready,
  input logic osc_irq,
  input logic pend_flag,
  input logic byp_flag,
  input logic clk_out,
  input logic div_ce,
  input logic stable_q,
  input logic start_evt,
  input logic done_evt
);

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !stable_q); // R2
  AST_PEND_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> pend_flag); // R3
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    osc_irq |-> pend_flag); // R4
  AST_PEND_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_pend_clr && !done_evt) |=> !pend_flag); // R5
  AST_BYP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    byp_flag |=> byp_flag); // R6
  AST_BYP_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
    byp_flag |-> (osc_ready && clk_out == ext_clk)); // R7
  AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_en && !byp_flag) |-> (!clk_out && !div_ce)); // R8
  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |=> !stable_q); // R9

endmodule

bind xosc_ctl xosc_ctl_chk u_chk (.*);

// File: tb/sim_xosc_ctl.sv
`timescale 1ns/1ps
module sim_xosc_ctl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       osc_en, ext_clk, wr_en, wr_mask, wr_byp, wr_pend_clr;
  logic [7:0] wr_eoc;
  logic [4:0] wr_div;
  logic       osc_ready, osc_irq, pend_flag, byp_flag, clk_out, div_ce;

  int nvec = 0;
  int nerr = 0;
  logic finished = 1'b0;

  // Shadow of the last written fields, so each write keeps the others.
  logic [7:0] s_eoc  = '0;
  logic       s_mask = 1'b0;
  logic [4:0] s_div  = '0;

  always #4 clk = ~clk;

  xosc_ctl u0 (
    .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .ext_clk(ext_clk),
    .wr_en(wr_en), .wr_eoc(wr_eoc), .wr_mask(wr_mask), .wr_div(wr_div),
    .wr_byp(wr_byp), .wr_pend_clr(wr_pend_clr),
    .osc_ready(osc_ready), .osc_irq(osc_irq), .pend_flag(pend_flag),
    .byp_flag(byp_flag), .clk_out(clk_out), .div_ce(div_ce)
  );

  task automatic chk(input int act, input int exp, input string req, input string what);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Called at a negedge; the write is sampled at the next rising edge.
  task automatic wr(input logic [7:0] e, input logic m, input logic [4:0] d,
                    input logic b, input logic c);
    s_eoc = e; s_mask = m; s_div = d;
    wr_en = 1'b1; wr_eoc = e; wr_mask = m; wr_div = d; wr_byp = b; wr_pend_clr = c;
    @(negedge clk);
    wr_en = 1'b0; wr_byp = 1'b0; wr_pend_clr = 1'b0;
  endtask

  // Counts negedges up to and including the next one with div_ce high.
  task automatic wait_ce(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!div_ce && k < 200);
  endtask

  // Enables at the current negedge, counts negedges until ready.
  task automatic measure_start(output int n);
    osc_en = 1'b1;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!osc_ready && n < 5000);
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    osc_en = 0; ext_clk = 0; wr_en = 0; wr_eoc = 0; wr_mask = 0;
    wr_div = 0; wr_byp = 0; wr_pend_clr = 0;
    s_eoc = 0; s_mask = 0; s_div = 0;
    tick(3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nerr++; nvec++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int n, k;
    do_reset();
    ext_clk = 1'b1; #1;
    // R1: in-reset state
    chk(osc_ready, 0, "R1", "ready in reset");
    chk(osc_irq,   0, "R1", "irq in reset");
    chk(pend_flag, 0, "R1", "pend in reset");
    chk(byp_flag,  0, "R1", "bypass in reset");
    chk(clk_out,   0, "R1", "clk_out in reset");
    chk(div_ce,    0, "R1", "div_ce in reset");
    rst_n = 1'b1;
    tick(1);
    chk(osc_ready, 0, "R1", "ready after release");
    chk(clk_out,   0, "R1", "clk_out after release");

    // R8: gating of the output clock
    for (int v = 0; v < 2; v++) begin
      ext_clk = v[0]; #1;
      chk(clk_out, 0, "R8", "powered down output");
    end
    osc_en = 1'b1;
    for (int v = 0; v < 2; v++) begin
      ext_clk = v[0]; #1;
      chk(clk_out, v, "R8", "enabled output follows input");
    end
    osc_en = 1'b0;
    tick(2);

    // R2/R3/R4/R5: startup sweep over small thresholds
    for (int e = 0; e < 4; e++) begin
      wr(8'(e), 1'b1, 5'd0, 1'b0, 1'b1);
      tick(1);
      chk(pend_flag, 0, "R5", "pend cleared before start");
      measure_start(n);
      // Ready is visible at the negedge after the (T+1)-th rising edge
      chk(n, e * 512 + 2, "R2", "startup latency in cycles");
      chk(pend_flag, 1, "R3", "pend set on completion");
      chk(osc_irq,   1, "R4", "irq with mask set");
      wr(8'(e), 1'b0, 5'd0, 1'b0, 1'b0);
      chk(osc_irq,   0, "R4", "irq masked");
      chk(pend_flag, 1, "R4", "pend kept while masked");
      wr(8'(e), 1'b1, 5'd0, 1'b0, 1'b0);
      chk(pend_flag, 1, "R5", "write 0 leaves pend");
      wr(8'(e), 1'b1, 5'd0, 1'b0, 1'b1);
      chk(pend_flag, 0, "R5", "write 1 clears pend");
      chk(osc_irq,   0, "R4", "irq follows cleared pend");
      osc_en = 1'b0;
      tick(1);
      chk(osc_ready, 0, "R9", "ready drops after disable");
    end

    // R9: partial count abandoned, re-enable restarts from zero
    wr(8'd1, 1'b1, 5'd0, 1'b0, 1'b1);
    osc_en = 1'b1;
    tick(300);
    osc_en = 1'b0;
    tick(2);
    measure_start(n);
    chk(n, 514, "R9", "restart takes full count");
    osc_en = 1'b0;
    wr(8'd1, 1'b1, 5'd0, 1'b0, 1'b1);
    tick(1);

    // R5: completion and clearing write on the same edge, set wins
    osc_en = 1'b1;
    tick(513);
    wr(8'd1, 1'b1, 5'd0, 1'b0, 1'b1);
    chk(osc_ready, 1, "R5", "ready at collision edge");
    chk(pend_flag, 1, "R5", "set wins over clear");
    wr(8'd1, 1'b1, 5'd0, 1'b0, 1'b1);
    chk(pend_flag, 0, "R5", "later clear works");

    // R10: all divide selectors with the path enabled
    for (int d = 0; d < 32; d++) begin
      wr(8'd1, 1'b1, 5'(d), 1'b0, 1'b0);
      wait_ce(k);
      wait_ce(k);
      wait_ce(k);
      chk(k, d + 1, "R10", "divide period");
      wait_ce(k);
      chk(k, d + 1, "R10", "divide period repeat");
    end

    // R11: change mid-period, old period completes first
    wr(8'd1, 1'b1, 5'd7, 1'b0, 1'b0);
    wait_ce(k);
    wait_ce(k);
    wait_ce(k);
    tick(3);
    wr(8'd1, 1'b1, 5'd2, 1'b0, 1'b0);
    wait_ce(k);
    chk(k + 4, 8, "R11", "running period keeps old length");
    wait_ce(k);
    chk(k, 3, "R11", "new period after terminal count");

    // R10: no pulses with the path inactive
    osc_en = 1'b0;
    n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (div_ce) n++;
    end
    chk(n, 0, "R10", "no div_ce while inactive");

    // R6/R7: sticky bypass
    wr(8'd1, 1'b1, 5'd2, 1'b0, 1'b0);
    chk(byp_flag, 0, "R6", "write 0 leaves bypass off");
    chk(osc_ready, 0, "R7", "not ready before bypass");
    wr(8'd1, 1'b1, 5'd2, 1'b1, 1'b0);
    chk(byp_flag, 1, "R6", "write 1 sets bypass");
    chk(osc_ready, 1, "R7", "bypass forces ready, enable off");
    for (int v = 0; v < 2; v++) begin
      ext_clk = v[0]; #1;
      chk(clk_out, v, "R7", "bypass output follows input");
    end
    wait_ce(k);
    wait_ce(k);
    chk(k, 3, "R10", "divider runs in bypass");
    wr(8'd1, 1'b1, 5'd2, 1'b0, 1'b0);
    chk(byp_flag, 1, "R6", "bypass not cleared by write");
    osc_en = 1'b1;
    tick(3);
    chk(osc_ready, 1, "R7", "ready with enable on in bypass");
    osc_en = 1'b0;
    tick(3);
    chk(osc_ready, 1, "R7", "ready after enable off in bypass");
    do_reset();
    chk(byp_flag, 0, "R6", "reset clears bypass");
    chk(osc_ready, 0, "R1", "ready after second reset");
    rst_n = 1'b1;
    tick(2);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

endmodule